// File: doc/BRIEF.md
# Interrupting General-Purpose Pin Port

This block is a 32-pin general-purpose I/O port placed behind a plain single-cycle register bus. Software sets each pin's direction and output value. It reads back the pad levels through a two-stage synchronizer. Each pin can be armed to flag an interrupt when its input is at a given level, or when it changes.

Each pin has a 2-bit trigger mode. The modes for pins 0 to 15 sit in one configuration word and the modes for pins 16 to 31 sit in a second word. A separate per-pin "any-change" bit overrides the 2-bit mode, so that the pin fires on both edges. Detected events are latched in a sticky flag word that software clears by writing 1s. The flag word is ANDed with an enable word and reduced to a single request line.

Writes take effect on the clock edge on which `wr_en` is high. Reads are combinational: `rdata` reflects the addressed register in the same cycle that `rd_en` is high, and is zero otherwise.

Top module: `pin_port_irq`

## Requirements
- R1: After reset, every register holds zero. `pad_out`, `pad_oe` and `irq` are low, and the flag word reads zero once the level-low events from the zeroed mode words have been cleared.
- R2: A write to byte offset 0x04 sets the direction word, which drives `pad_oe` from the next cycle (1 = output). A write to offset 0x00 sets the output word, which drives `pad_out`.
- R3: A read of offset 0x00 returns the written output bit for output pins and the synchronized pad level for input pins.
- R4: A read of offset 0x08 returns `pad_in` delayed by two clock edges. Writes to offset 0x08 have no effect.
- R5: Offset 0x0C holds the modes of pins 0–15 and offset 0x10 holds the modes of pins 16–31. Pin n uses bits [2(n mod 16)+1 : 2(n mod 16)]. Mode 0 flags a low level and mode 1 flags a high level.
- R6: Mode 2 flags a 0→1 change of the synchronized input and mode 3 flags a 1→0 change. Both are found by comparing the synchronized input with its previous sample.
- R7: When a pin's bit in the any-change word (offset 0x1C) is 1, that pin flags every change in either direction and never flags a steady level, whatever its mode.
- R8: The flag word (offset 0x18) is sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A level-mode flag returns on the next cycle while its level persists.
- R9: When a new event and a clearing write hit the same bit on the same edge, the bit ends set.
- R10: `irq` is high exactly when some flag bit is set whose bit in the enable word (offset 0x14) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte address; bits [4:2] select the register |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when `rd_en` is low |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Interrupt request |

## Verification
A stale flag bit or a wrong mode decode shows up on the flag-word read within three edges of a pad change: two edges for the synchronizer and one for the latch. It shows on `irq` in the same cycle as the latch. A lost synchronizer stage moves the pad-status read one cycle early, so the bench samples that read on both sides of the two-edge boundary. A wrong clear-versus-set priority only shows when the clearing write lands on the exact edge on which the event latches, so the bench aims a write at that edge and again one edge later.

// File: rtl/pin_port_irq.sv
module pin_port_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe,
  output logic        irq
);
  localparam int NPIN = 32;

  localparam logic [2:0] SEL_OUT  = 3'd0;
  localparam logic [2:0] SEL_DIR  = 3'd1;
  localparam logic [2:0] SEL_PAD  = 3'd2;
  localparam logic [2:0] SEL_MLO  = 3'd3;
  localparam logic [2:0] SEL_MHI  = 3'd4;
  localparam logic [2:0] SEL_EN   = 3'd5;
  localparam logic [2:0] SEL_FLAG = 3'd6;
  localparam logic [2:0] SEL_ANY  = 3'd7;

  logic [NPIN-1:0]   out_q, dir_q, en_q, flag_q, any_q;
  logic [NPIN-1:0]   meta_q, sync_q, last_q, evt;
  logic [2*NPIN-1:0] mode_q;
  logic [2:0]        sel;

  assign sel = addr[4:2];

  wire wr_flag = wr_en && sel == SEL_FLAG;

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign irq     = |(flag_q & en_q);

  always_comb begin
    for (int i = 0; i < NPIN; i++) begin
      if (any_q[i])
        evt[i] = sync_q[i] ^ last_q[i];
      else
        case (mode_q[2*i +: 2])
          2'd0:    evt[i] = ~sync_q[i];
          2'd1:    evt[i] = sync_q[i];
          2'd2:    evt[i] = sync_q[i] & ~last_q[i];
          default: evt[i] = ~sync_q[i] & last_q[i];
        endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      last_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      en_q   <= '0;
      any_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_OUT: out_q                  <= wdata;
        SEL_DIR: dir_q                  <= wdata;
        SEL_MLO: mode_q[NPIN-1:0]       <= wdata;
        SEL_MHI: mode_q[2*NPIN-1:NPIN]  <= wdata;
        SEL_EN:  en_q                   <= wdata;
        SEL_ANY: any_q                  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~(wr_flag ? wdata : '0)) | evt;
  end

  always_comb begin
    rdata = '0;
    if (rd_en)
      case (sel)
        SEL_OUT:  rdata = (out_q & dir_q) | (sync_q & ~dir_q);
        SEL_DIR:  rdata = dir_q;
        SEL_PAD:  rdata = sync_q;
        SEL_MLO:  rdata = mode_q[NPIN-1:0];
        SEL_MHI:  rdata = mode_q[2*NPIN-1:NPIN];
        SEL_EN:   rdata = en_q;
        SEL_FLAG: rdata = flag_q;
        default:  rdata = any_q;
      endcase
  end

  AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DIR) |=> pad_oe == $past(wdata)); // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> (flag_q & $past(wdata & ~evt)) == '0); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (flag_q & $past(evt)) == $past(evt)); // R9
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != $past(flag_q)) |-> (flag_q & ~$past(flag_q) & ~$past(evt)) == '0); // R6
  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R10
endmodule

// File: tb/sim_pin_port_irq.sv
module sim_pin_port_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_port_irq u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata; rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] lvl(int m, bit e, logic [31:0] v);
    if (e || m > 1) return '0;
    return m == 0 ? ~v : v;
  endfunction

  function automatic logic [31:0] edg(int m, bit e, logic [31:0] o, logic [31:0] n);
    if (e) return o ^ n;
    if (m == 2) return n & ~o;
    if (m == 3) return o & ~n;
    return '0;
  endfunction

  initial begin
    #(5 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    if (!done) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, o, n, x;
    idle(3);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(5'h00, v); chk("R1 data", v, 0);
    rd(5'h04, v); chk("R1 dir", v, 0);
    rd(5'h14, v); chk("R1 enable", v, 0);
    rd(5'h1C, v); chk("R1 anychange", v, 0);
    rd(5'h0C, v); chk("R1 mode lo", v, 0);
    wr(5'h0C, 32'h5555_5555); wr(5'h10, 32'h5555_5555);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); chk("R1 flags after clear", v, 0);

    wr(5'h04, 32'h0000_FFFF);
    wr(5'h00, 32'h1234_5678);
    chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    chk("R2 pad_out", pad_out, 32'h1234_5678);
    pad_in = 32'hABCD_0F0F; idle(3);
    rd(5'h00, v); chk("R3 data mix", v, 32'hABCD_5678);
    wr(5'h04, 32'hFF00_0000);
    rd(5'h00, v); chk("R3 data mix 2", v, 32'h12CD_0F0F);

    rd(5'h08, v); chk("R4 pad status", v, 32'hABCD_0F0F);
    wr(5'h08, 32'h0);
    rd(5'h08, v); chk("R4 write ignored", v, 32'hABCD_0F0F);
    pad_in = 32'h0F0F_1234;
    rd(5'h08, v); chk("R4 one edge", v, 32'hABCD_0F0F);
    rd(5'h08, v); chk("R4 two edges", v, 32'h0F0F_1234);

    pad_in = 32'h0; wr(5'h0C, 32'h1 << 10); wr(5'h10, 32'h1 << 8);
    idle(3); wr(5'h18, 32'hFFFF_FFFF); idle(2);
    rd(5'h18, v); chk("R5 field layout", v, ~((32'h1 << 5) | (32'h1 << 20)));

    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 2; e++) begin
        wr(5'h0C, {16{m[1:0]}}); wr(5'h10, {16{m[1:0]}});
        wr(5'h1C, e ? 32'hFFFF_FFFF : 32'h0);
        for (int p = 0; p < 32; p++) begin
          o = p[0] ? 32'hFFFF_FFFF : 32'h0;
          n = o ^ (32'h1 << p);
          pad_in = o; wr(5'h14, 32'h1 << p); idle(4);
          @(negedge clk); addr = 5'h18; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
          @(negedge clk); wr_en = 1'b0; pad_in = n;
          idle(4);
          x = lvl(m, e, o) | lvl(m, e, n) | edg(m, e, o, n);
          rd(5'h18, v);
          chk(e ? "R7 any change" : (m > 1 ? "R6 edge mode" : "R5 level mode"), v, x);
          chk("R10 irq", {31'd0, irq}, {31'd0, x[p]});
          wr(5'h18, 32'hFFFF_FFFF); idle(1);
          rd(5'h18, v); chk("R8 clear then level", v, lvl(m, e, n));
        end
      end

    wr(5'h1C, 0); wr(5'h0C, 32'hAAAA_AAAA); wr(5'h10, 32'hAAAA_AAAA);
    wr(5'h14, 32'hFFFF_FFFF); pad_in = 0; idle(4); wr(5'h18, 32'hFFFF_FFFF);
    chk("R10 idle irq", {31'd0, irq}, 0);
    wr(5'h18, 32'h0);
    pad_in = 32'h1 << 3; idle(4);
    wr(5'h18, 32'h0);
    rd(5'h18, v); chk("R8 write zero keeps", v, 32'h1 << 3);
    wr(5'h18, 32'h1 << 3);
    rd(5'h18, v); chk("R8 write one clears", v, 0);

    @(negedge clk); pad_in = 32'h1 << 7;
    @(negedge clk); @(negedge clk);
    addr = 5'h18; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(5'h18, v); chk("R9 set wins", v, 32'h1 << 7);
    pad_in = 0; idle(4); wr(5'h18, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 32'h1 << 7;
    @(negedge clk); @(negedge clk); @(negedge clk);
    addr = 5'h18; wdata = 32'hFFFF_FFFF; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(5'h18, v); chk("R9 later clear", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule